// File: doc/BRIEF.md
# SPI Frame Timing Generator

This block produces the complete timing of one SPI frame from a single 31-bit attribute word. The word sets several things: the SCK rate, the SCK idle level, which edge samples and which edge shifts, the frame length, the bit order, and three delays. The delays are the chip-select-to-first-edge lead, the last-edge-to-release lag, and a recovery gap that follows a release. Every rate and delay is a small odd or prime prescaler multiplied by a binary scaler. The result is counted in functional clock cycles.

A requester pulses `start_i` together with the attribute word and a keep flag. The block first requests chip-select assertion. It then waits out the lead time and toggles SCK twice per bit. It gives single-cycle shift and sample strobes and a bit index that a neighbouring shifter uses. After the lag it reports frame end. If the keep flag was clear, it requests chip-select release and then waits out the recovery gap. If the keep flag was set, chip select stays asserted and the next frame can start at once. A start that arrives while the block is busy is held and served later.

Top module: `spi_frame_timer`

## Requirements
- R1: Attribute bits [17:16] pick a rate prescaler P of 2, 3, 5 or 7 for codes 0 to 3. Bits [3:0] pick a rate scaler S: code c gives 2(c+1) for c below 4 and 2^c otherwise. The SCK period is P·S clock cycles, and each SCK level lasts P·S/2 cycles (call this H).
- R2: A delay with prescaler code p and scaler code s lasts (2p+1)·2^(s+1) clock cycles. The lead uses bits [23:22] and [15:12]. Call the lead L. The first SCK edge comes L+H cycles after the chip-select assert request. Each later edge follows the previous one by H cycles.
- R3: The frame length B is bits [30:27] plus one. A frame has exactly 2B SCK edges, and the last edge returns SCK to its idle level.
- R4: Bit 26 is the SCK idle level. It is applied in the cycle a frame is accepted and is kept until the next frame is accepted. After reset the level is 0.
- R5: Odd-numbered edges are leading edges. With bit 25 clear, `sample_o` pulses on each leading edge and `shift_o` pulses on each trailing edge except the last. With bit 25 set, `shift_o` pulses on leading edges and `sample_o` pulses on trailing edges. Each strobe lasts one cycle and coincides with its SCK change. The two strobes never pulse together.
- R6: During bit period k (0-based) `bit_idx_o` shows k when bit 24 is set, and (B-1-k) when it is clear. It shows the first bit's index from acceptance until the first bit period. It holds the last index after the final edge.
- R7: The lag uses bits [21:20] and [11:8]. `done_o` pulses for one cycle a lag later than the last SCK edge.
- R8: If keep was clear, `cs_negate_o` pulses in the same cycle as `done_o`. The next frame is then accepted no earlier than a recovery gap plus one cycle after that pulse. The recovery gap uses bits [19:18] and [7:4].
- R9: If keep was set, there is no release request and no recovery gap. A frame accepted while chip select is still asserted gives no `cs_assert_o` pulse.
- R10: A start seen while a frame or a gap is in progress is held with its word and keep flag. It is accepted one cycle after the block becomes idle. Only one start is held: further starts seen while one is pending have no effect.
- R11: During reset, and right after it, SCK is 0, `bit_idx_o` is 0 and no strobe or request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request one frame |
| attr_i | input | 31 | Attribute word, sampled with `start_i` |
| keep_cs_i | input | 1 | Keep chip select asserted after this frame |
| sck_o | output | 1 | Serial clock |
| shift_o | output | 1 | One-cycle strobe to drive the next bit |
| sample_o | output | 1 | One-cycle strobe to capture the incoming bit |
| bit_idx_o | output | 4 | Index of the bit in its period |
| cs_assert_o | output | 1 | One-cycle request to assert chip select |
| cs_negate_o | output | 1 | One-cycle request to release chip select |
| done_o | output | 1 | One-cycle pulse at frame end |

## Verification
The hardest cases to reach are the held start and the ignored second start. Both need a request to land in a chosen cycle while a frame or the recovery gap is running. The stimulus computes each frame's edge, lag and gap cycles ahead of time from the attribute word. It fires one start in the middle of a kept frame and a second one a few cycles later. It also fires a start inside a long recovery gap. The expected acceptance cycles, and the missing third frame, then show up as exact SCK and request times at the ports.

// File: rtl/spi_tim_pkg.sv
// Package for the SPI frame timing generator.
// Holds the attribute field layout, the decoded timing type, the FSM state
// type and the arithmetic that turns prescaler and scaler codes into cycle counts.
// Assumes that every count fits in CNT_W bits (the largest is 7 * 2^16).
package spi_tim_pkg;

    localparam int ATTR_W = 31;
    localparam int CNT_W  = 20;
    localparam int FSZ_W  = 4;
    localparam int PH_W   = FSZ_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_XFER,
        ST_LAG,
        ST_GAP
    } tim_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] lead;
        logic [CNT_W-1:0] lag;
        logic [CNT_W-1:0] gap;
        logic [CNT_W-1:0] half;
        logic [FSZ_W-1:0] fsz;
        logic             cpol;
        logic             cpha;
        logic             lsb;
    } tim_cfg_t;

    // Delay: odd prescaler (2p+1) times a power of two 2^(s+1).
    function automatic logic [CNT_W-1:0] delay_cycles(input logic [1:0] pre,
                                                      input logic [3:0] sc);
        logic [CNT_W-1:0] base;
        base = CNT_W'({pre, 1'b1});
        return base << ({1'b0, sc} + 5'd1);
    endfunction

    // Full SCK period: prescaler {2,3,5,7} times scaler {2,4,6,8,16..32768}.
    function automatic logic [CNT_W-1:0] baud_cycles(input logic [1:0] pre,
                                                     input logic [3:0] sc);
        logic [CNT_W-1:0] p;
        logic [CNT_W-1:0] s;
        case (pre)
            2'd0:    p = CNT_W'(2);
            2'd1:    p = CNT_W'(3);
            2'd2:    p = CNT_W'(5);
            default: p = CNT_W'(7);
        endcase
        if (sc < 4'd4) s = CNT_W'({sc, 1'b0}) + CNT_W'(2);
        else           s = CNT_W'(1) << sc;
        return CNT_W'(p * s);
    endfunction

endpackage

// File: rtl/spi_attr_decode.sv
// Attribute decoder: splits the attribute word into its fields and converts
// the rate and delay codes into cycle counts.
// Assumes the rate product is always even (each scaler is even), so the
// SCK high and low levels have the same length, half the period.
module spi_attr_decode
    import spi_tim_pkg::*;
(
    input  logic [ATTR_W-1:0] attr,
    output tim_cfg_t          cfg
);

    logic [CNT_W-1:0] period;

    // Field extraction and count arithmetic.
    always_comb begin
        period       = baud_cycles(attr[17:16], attr[3:0]);
        cfg.fsz      = attr[30:27];
        cfg.cpol     = attr[26];
        cfg.cpha     = attr[25];
        cfg.lsb      = attr[24];
        cfg.lead     = delay_cycles(attr[23:22], attr[15:12]);
        cfg.lag      = delay_cycles(attr[21:20], attr[11:8]);
        cfg.gap      = delay_cycles(attr[19:18], attr[7:4]);
        cfg.half     = period >> 1;
    end

endmodule

// File: rtl/spi_down_counter.sv
// Loadable down counter that times every interval of the frame.
// Loading N-1 gives an interval of N cycles, ending when zero is seen.
// Assumes the loader never asks for a zero-length interval.
module spi_down_counter #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    // Count register: load wins, otherwise step down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (load)             cnt_q <= load_val;
        else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
    end

    // Zero flag that ends the current interval.
    always_comb zero = (cnt_q == '0);

    // R2: an interval shortens by exactly one each cycle when not reloaded.
    a_r2_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/spi_frame_timer.sv
// SPI frame timing generator (top).
// Accepts a start with an attribute word. It then asserts chip select and
// runs the lead, the SCK toggling, the lag and, when chip select is
// released, the recovery gap. Shift and sample strobes and a bit index go
// out for a neighbouring shift register.
// Assumes the frame-size field gives 4..16 bits and the attribute word is
// only read in the cycle a frame is accepted. One start is held while busy.
module spi_frame_timer
    import spi_tim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ATTR_W-1:0] attr_i,
    input  logic              keep_cs_i,
    output logic              sck_o,
    output logic              shift_o,
    output logic              sample_o,
    output logic [FSZ_W-1:0]  bit_idx_o,
    output logic              cs_assert_o,
    output logic              cs_negate_o,
    output logic              done_o
);

    tim_state_e        state_q;
    logic [ATTR_W-1:0] cur_attr_q;
    logic              cur_keep_q;
    logic              pend_q;
    logic [ATTR_W-1:0] pend_attr_q;
    logic              pend_keep_q;
    logic              cs_on_q;
    logic [PH_W-1:0]   ph_q;

    logic              take;
    logic [ATTR_W-1:0] in_attr;
    logic              in_keep;
    logic [ATTR_W-1:0] sel_attr;
    tim_cfg_t          cfg;
    logic              zero;
    logic              ld;
    logic [CNT_W-1:0]  ld_val;
    logic              last_edge;
    logic              lead_edge;
    logic [FSZ_W-1:0]  next_ord;
    logic [FSZ_W-1:0]  next_idx;
    logic [FSZ_W-1:0]  first_idx;

    // Source of the next frame: the held request first, otherwise the ports.
    always_comb begin
        in_attr  = pend_q ? pend_attr_q : attr_i;
        in_keep  = pend_q ? pend_keep_q : keep_cs_i;
        take     = (state_q == ST_IDLE) && (pend_q || start_i);
        sel_attr = (state_q == ST_IDLE) ? in_attr : cur_attr_q;
    end

    spi_attr_decode u_dec (
        .attr (sel_attr),
        .cfg  (cfg)
    );

    // Edge bookkeeping: which edge comes next and which bit it belongs to.
    always_comb begin
        last_edge = (ph_q == {cfg.fsz, 1'b1});
        lead_edge = ~ph_q[0];
        next_ord  = FSZ_W'((ph_q + 1'b1) >> 1);
        next_idx  = cfg.lsb ? next_ord : (cfg.fsz - next_ord);
        first_idx = cfg.lsb ? '0 : cfg.fsz;
    end

    // Interval loader: picks the length of the interval that begins next.
    always_comb begin
        ld     = 1'b0;
        ld_val = '0;
        case (state_q)
            ST_IDLE: if (take) begin
                ld     = 1'b1;
                ld_val = cfg.lead - CNT_W'(1);
            end
            ST_LEAD: if (zero) begin
                ld     = 1'b1;
                ld_val = cfg.half - CNT_W'(1);
            end
            ST_XFER: if (zero) begin
                ld     = 1'b1;
                ld_val = last_edge ? (cfg.lag - CNT_W'(1)) : (cfg.half - CNT_W'(1));
            end
            ST_LAG: if (zero && !cur_keep_q) begin
                ld     = 1'b1;
                ld_val = cfg.gap - CNT_W'(1);
            end
            default: begin
                ld     = 1'b0;
                ld_val = '0;
            end
        endcase
    end

    spi_down_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .zero     (zero)
    );

    // Held-start register: captures one request that arrives while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_attr_q <= '0;
            pend_keep_q <= 1'b0;
        end else if (take && pend_q) begin
            pend_q <= start_i;
            if (start_i) begin
                pend_attr_q <= attr_i;
                pend_keep_q <= keep_cs_i;
            end
        end else if (!take && start_i && !pend_q) begin
            pend_q      <= 1'b1;
            pend_attr_q <= attr_i;
            pend_keep_q <= keep_cs_i;
        end
    end

    // Frame sequencer: state, phase, SCK level, bit index and pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cur_attr_q  <= '0;
            cur_keep_q  <= 1'b0;
            cs_on_q     <= 1'b0;
            ph_q        <= '0;
            sck_o       <= 1'b0;
            shift_o     <= 1'b0;
            sample_o    <= 1'b0;
            bit_idx_o   <= '0;
            cs_assert_o <= 1'b0;
            cs_negate_o <= 1'b0;
            done_o      <= 1'b0;
        end else begin
            shift_o     <= 1'b0;
            sample_o    <= 1'b0;
            cs_assert_o <= 1'b0;
            cs_negate_o <= 1'b0;
            done_o      <= 1'b0;
            case (state_q)
                ST_IDLE: if (take) begin
                    state_q     <= ST_LEAD;
                    cur_attr_q  <= in_attr;
                    cur_keep_q  <= in_keep;
                    cs_assert_o <= !cs_on_q;
                    cs_on_q     <= 1'b1;
                    sck_o       <= cfg.cpol;
                    bit_idx_o   <= first_idx;
                    ph_q        <= '0;
                end
                ST_LEAD: if (zero) begin
                    state_q <= ST_XFER;
                    ph_q    <= '0;
                end
                ST_XFER: if (zero) begin
                    if (cfg.cpha) begin
                        shift_o  <= lead_edge;
                        sample_o <= !lead_edge;
                    end else begin
                        sample_o <= lead_edge;
                        shift_o  <= !lead_edge && !last_edge;
                    end
                    if (last_edge) begin
                        state_q <= ST_LAG;
                        sck_o   <= cfg.cpol;
                    end else begin
                        ph_q      <= ph_q + 1'b1;
                        sck_o     <= ~sck_o;
                        bit_idx_o <= next_idx;
                    end
                end
                ST_LAG: if (zero) begin
                    done_o <= 1'b1;
                    if (cur_keep_q) begin
                        state_q <= ST_IDLE;
                    end else begin
                        cs_negate_o <= 1'b1;
                        cs_on_q     <= 1'b0;
                        state_q     <= ST_GAP;
                    end
                end
                ST_GAP: if (zero) begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R5: the two data strobes never coincide.
    a_r5_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_o && sample_o));

    // R5: each strobe sits on an SCK change.
    a_r5_strobe_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_o || sample_o) |-> !$stable(sck_o));

    // R4: SCK rests at the idle level during the lag and the gap.
    a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LAG || state_q == ST_GAP) |-> (sck_o == cfg.cpol));

    // R8: a release request only comes with frame end.
    a_r8_negate_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        cs_negate_o |-> done_o);

    // R9: a kept frame returns straight to idle, with no gap.
    a_r9_keep_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cs_negate_o) |-> (state_q == ST_IDLE));

    // R10: a start seen while busy is held.
    a_r10_hold_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && state_q != ST_IDLE && !pend_q) |=> pend_q);

    // R9: assert request only at the start of a lead.
    a_r9_assert_in_lead: assert property (@(posedge clk) disable iff (!rst_n)
        cs_assert_o |-> (state_q == ST_LEAD));

endmodule

// File: tb/tb_spi_frame_timer.sv
// Scoreboard bench: a model task pushes expected port events with their
// cycle numbers; a monitor pops them as the design shows them.
module tb_spi_frame_timer;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        int    kind;
        int    cyc;
        int    val;
        string tag;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [30:0] attr_i = '0;
    logic        keep_cs_i = 1'b0;
    logic        sck_o, shift_o, sample_o, cs_assert_o, cs_negate_o, done_o;
    logic [3:0]  bit_idx_o;

    int  cyc = 0;
    int  n_chk = 0;
    int  n_fail = 0;
    bit  fin = 1'b0;
    bit  m_cs_on = 1'b0;
    int  m_sck = 0;
    logic prev_sck = 1'b0;
    ev_t exp_q[$];

    spi_frame_timer dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .attr_i (attr_i),
        .keep_cs_i (keep_cs_i), .sck_o (sck_o), .shift_o (shift_o),
        .sample_o (sample_o), .bit_idx_o (bit_idx_o), .cs_assert_o (cs_assert_o),
        .cs_negate_o (cs_negate_o), .done_o (done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [30:0] mk(int fsz, int cpol, int cpha, int lsb,
                                       int lp, int gp, int xp, int bp,
                                       int ls, int gs, int xs, int bs);
        return {4'(fsz), 1'(cpol), 1'(cpha), 1'(lsb), 2'(lp), 2'(gp), 2'(xp),
                2'(bp), 4'(ls), 4'(gs), 4'(xs), 4'(bs)};
    endfunction

    function automatic int dly(int p, int s);
        return (2 * p + 1) * (2 << s);
    endfunction

    function automatic int period(int p, int s);
        int pv;
        int sv;
        case (p)
            0: pv = 2;
            1: pv = 3;
            2: pv = 5;
            default: pv = 7;
        endcase
        sv = (s < 4) ? 2 * (s + 1) : (1 << s);
        return pv * sv;
    endfunction

    task automatic push(int kind, int c, int v, string tag);
        ev_t e;
        e.kind = kind; e.cyc = c; e.val = v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Expected events of one frame accepted at edge e0; returns the idle cycle.
    task automatic model_frame(input logic [30:0] a, input bit keep, input int e0,
                               input string first_tag, output int idle_cyc);
        int fsz, nb, cpol, cpha, lsb, l, g, x, h, c, lvl, ord, idx, ed;
        bit lead, samp, shf;
        string t;
        bit first;
        first = 1'b1;
        fsz  = int'(a[30:27]); nb = fsz + 1;
        cpol = int'(a[26]); cpha = int'(a[25]); lsb = int'(a[24]);
        l = dly(int'(a[23:22]), int'(a[15:12]));
        g = dly(int'(a[21:20]), int'(a[11:8]));
        x = dly(int'(a[19:18]), int'(a[7:4]));
        h = period(int'(a[17:16]), int'(a[3:0])) / 2;
        if (!m_cs_on) begin
            push(0, e0, 0, first ? first_tag : "R9");
            first = 1'b0;
        end
        m_cs_on = 1'b1;
        if (cpol != m_sck) begin
            idx = lsb ? 0 : fsz;
            push(1, e0, idx * 2 + cpol, first ? first_tag : "R4");
            first = 1'b0;
        end
        m_sck = cpol;
        for (int n = 1; n <= 2 * nb; n++) begin
            c    = e0 + l + n * h;
            lvl  = (n < 2 * nb) ? (cpol ^ (n & 1)) : cpol;
            ord  = (n < 2 * nb) ? (n >> 1) : (nb - 1);
            idx  = lsb ? ord : (fsz - ord);
            t    = (n == 1) ? "R2" : (n == 2 * nb) ? "R3" : (lsb ? "R6" : "R1");
            push(1, c, idx * 2 + lvl, t);
            lead = (n & 1) == 1;
            samp = cpha ? !lead : lead;
            shf  = cpha ? lead : (!lead && n < 2 * nb);
            if (samp) push(2, c, 0, "R5");
            if (shf)  push(3, c, 0, "R5");
            m_sck = lvl;
        end
        ed = e0 + l + 2 * nb * h + g;
        push(4, ed, 0, "R7");
        if (!keep) begin
            push(5, ed, 0, "R8");
            m_cs_on = 1'b0;
            idle_cyc = ed + x;
        end else begin
            idle_cyc = ed;
        end
    endtask

    task automatic cmp(int kind, int v);
        ev_t e;
        n_chk++;
        if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R10: unexpected kind %0d at cycle %0d value %0d, expected nothing",
                     kind, cyc, v);
            return;
        end
        e = exp_q.pop_front();
        if (e.kind != kind || e.cyc != cyc || e.val != v) begin
            n_fail++;
            $display("FAIL %s: kind %0d cycle %0d value %0d, expected kind %0d cycle %0d value %0d",
                     e.tag, kind, cyc, v, e.kind, e.cyc, e.val);
        end
    endtask

    // Monitor: turns port activity into events and compares them in order.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_sck <= sck_o;
        end else begin
            if (cs_assert_o)      cmp(0, 0);
            if (sck_o != prev_sck) cmp(1, int'(bit_idx_o) * 2 + int'(sck_o));
            if (sample_o)         cmp(2, 0);
            if (shift_o)          cmp(3, 0);
            if (done_o)           cmp(4, 0);
            if (cs_negate_o)      cmp(5, 0);
            prev_sck <= sck_o;
        end
    end

    task automatic wait_until(int k);
        while (cyc < k) @(negedge clk);
    endtask

    task automatic fire(logic [30:0] a, bit keep);
        start_i = 1'b1; attr_i = a; keep_cs_i = keep;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        logic [30:0] f1, f2, f3, f4, f5, junk;
        int e0, idle1, idle2, idle3, idle4, idle5;
        f1   = mk(3, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0);
        f2   = mk(7, 1, 1, 1, 2, 0, 3, 1, 1, 0, 0, 1);
        f3   = mk(15, 0, 1, 0, 0, 0, 0, 3, 0, 0, 0, 0);
        f4   = mk(3, 1, 0, 0, 1, 2, 3, 2, 1, 0, 2, 3);
        f5   = mk(4, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 4);
        junk = mk(15, 1, 0, 1, 3, 3, 3, 3, 2, 2, 2, 2);

        repeat (4) @(negedge clk);
        // R11: reset state at the ports.
        n_chk++;
        if (sck_o !== 1'b0 || shift_o !== 1'b0 || sample_o !== 1'b0 ||
            cs_assert_o !== 1'b0 || cs_negate_o !== 1'b0 || done_o !== 1'b0 ||
            bit_idx_o !== 4'd0) begin
            n_fail++;
            $display("FAIL R11: outputs %b%b%b%b%b%b idx %0d, expected all 0",
                     sck_o, shift_o, sample_o, cs_assert_o, cs_negate_o, done_o, bit_idx_o);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R11: still quiet one cycle after reset release.
        n_chk++;
        if (sck_o !== 1'b0 || done_o !== 1'b0 || cs_assert_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R11: sck %b done %b assert %b, expected 0 0 0",
                     sck_o, done_o, cs_assert_o);
        end
        repeat (3) @(negedge clk);

        // R1 R2 R3 R5 R7 R8: plain frame, release at end.
        e0 = cyc + 1;
        model_frame(f1, 1'b0, e0, "R2", idle1);
        fire(f1, 1'b0);
        wait_until(idle1 + 2);

        // R4 R5 R6 R9: kept frame, LSB first, second-edge sampling.
        e0 = cyc + 1;
        model_frame(f2, 1'b1, e0, "R4", idle2);
        fire(f2, 1'b0 | 1'b1);
        wait_until(e0 + 4);
        // R10: held start during a kept frame, served one cycle after idle.
        model_frame(f3, 1'b0, idle2 + 1, "R10", idle3);
        fire(f3, 1'b0);
        wait_until(e0 + 7);
        // R10: a further start while one is held has no effect.
        fire(junk, 1'b0);
        wait_until(idle3 + 2);

        // R8: long recovery gap; a start inside it waits for the gap end.
        e0 = cyc + 1;
        model_frame(f4, 1'b0, e0, "R4", idle4);
        fire(f4, 1'b0);
        wait_until(idle4 - 54);
        model_frame(f5, 1'b0, idle4 + 1, "R10", idle5);
        fire(f5, 1'b0);
        wait_until(idle5 + 30);

        // R10: every expected event seen, and nothing from the dropped start.
        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R10: %0d events still expected, expected 0", exp_q.size());
        end
        fin = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!fin) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run not finished, expected completion");
            summary();
            $finish;
        end
    end

endmodule